// File: doc/BRIEF.md
# Digital PLL Loop Filter with Fractional Dither

This block sits between the phase detector and the oscillator of a digital PLL. On each reference cycle it takes the signed phase-error word and runs it through a proportional path and a saturating integral path. Together these two paths form the loop zero. A single-pole smoothing stage follows them and forms the loop pole, so the filter has the same pole and zero as a conventional analog loop filter. The gains of all three stages are power-of-two right shifts set by 4-bit configuration inputs.

The filter state is a fixed-point word with `FRAC_W` fractional bits. Its integer part becomes the oscillator control word. Its fractional part feeds a first-order sigma-delta accumulator, and the carry out of that accumulator is added to the integer word. Averaged over many reference cycles, the control word therefore tracks the filter output to a resolution finer than one integer step.

The block only acts on cycles where the update strobe is high. Every state register and the output word hold their values between updates.

Top module: `dpll_loop_filter`

## Requirements
- R1: After reset, `ctrl_word_o` is 0, `ctrl_strobe_o` is 0 and `sd_carry_o` is 0, and all internal filter state is zero.
- R2: The outputs change only in the clock cycle that follows a cycle with `upd_i` high. `ctrl_strobe_o` is high exactly in those cycles. When `upd_i` is low, `ctrl_word_o` holds its value and `phase_err_i` has no effect.
- R3: Let E be the error sign-extended to `ACC_W` bits and multiplied by 2^`FRAC_W`. The proportional term is E arithmetically right-shifted by `kp_shift_i` (0..15).
- R4: On each update, the integrator adds E arithmetically right-shifted by `ki_shift_i`. The sum of the proportional term and the updated integrator value is the filter input of that same update.
- R5: The integrator and the proportional-plus-integral sum both saturate at the signed `ACC_W` limits, -2^(ACC_W-1) and 2^(ACC_W-1)-1. They never wrap: a positive error never lowers the integrator, and a negative error never raises it.
- R6: The pole stage updates its state y as y + ((target - y) >>> `pole_shift_i`) using an arithmetic shift. A shift of 0 passes the target straight through.
- R7: On each update, the low `FRAC_W` bits of the new y are added, modulo 2^`FRAC_W`, to the sigma-delta accumulator. The carry out of that addition appears on `sd_carry_o` for the strobe cycle only, and the same carry is added to the integer part (y >>> `FRAC_W`) to form `ctrl_word_o`.
- R8: Consider a constant y with fractional value f and 2^`FRAC_W` updates. Exactly f of those updates produce a carry, and the sum of `ctrl_word_o` over them exceeds 2^`FRAC_W` times the integer part by exactly f.
- R9: When the integer part plus the carry exceeds the largest signed `CTRL_W`-bit value, `ctrl_word_o` is clamped to that largest value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| upd_i | input | 1 | Update strobe, one pulse per reference comparison |
| phase_err_i | input | ERR_W | Signed phase error (reference minus feedback) |
| kp_shift_i | input | 4 | Right shift applied in the proportional path |
| ki_shift_i | input | 4 | Right shift applied in the integral path |
| pole_shift_i | input | 4 | Right shift of the smoothing pole |
| ctrl_word_o | output | CTRL_W | Signed oscillator control word, CTRL_W = ACC_W - FRAC_W |
| ctrl_strobe_o | output | 1 | High for one cycle after each update |
| sd_carry_o | output | 1 | Sigma-delta carry of the latest update |

## Verification
The hardest states to reach are the saturation rails of the integrator and the clamp of the control word. With default widths, a single full-scale error moves the integrator by only about one sixteenth of its range. The bench therefore sets the integral shift to zero and repeats a full-scale error for more than sixteen updates until the positive rail is reached, then applies a small opposite error to confirm the value steps back down instead of wrapping. The negative rail is reached the same way. The dither density is checked by planting an exact fraction in the integrator with a single shifted error, then running a full 2^FRAC_W-update window with zero error and counting the carries.

// File: rtl/dpll_lf_pkg.sv
package dpll_lf_pkg;
    localparam int SHIFT_W = 4;

    typedef struct packed {
        logic [SHIFT_W-1:0] kp;
        logic [SHIFT_W-1:0] ki;
        logic [SHIFT_W-1:0] kpole;
    } lf_gains_t;
endpackage

// File: rtl/lf_sat_add.sv
// Signed adder that clips to the representable range instead of wrapping.
module lf_sat_add #(
    parameter int W = 24
) (
    input  logic signed [W-1:0] a_i,
    input  logic signed [W-1:0] b_i,
    output logic signed [W-1:0] sum_o
);
    logic [W:0] wide;

    always_comb begin
        wide = {a_i[W-1], a_i} + {b_i[W-1], b_i};
        if (wide[W] != wide[W-1]) begin
            sum_o = wide[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        end else begin
            sum_o = wide[W-1:0];
        end
    end
endmodule

// File: rtl/lf_integrator.sv
// Integral path: accumulates the shifted error, clipping at the rails.
module lf_integrator #(
    parameter int ACC_W   = 24,
    parameter int SHIFT_W = 4
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     upd_i,
    input  logic signed [ACC_W-1:0]  err_scaled_i,
    input  logic [SHIFT_W-1:0]       ki_i,
    output logic signed [ACC_W-1:0]  integ_next_o,
    output logic signed [ACC_W-1:0]  integ_q_o
);
    logic signed [ACC_W-1:0] step;
    logic signed [ACC_W-1:0] sum_sat;
    logic signed [ACC_W-1:0] integ_d;
    logic signed [ACC_W-1:0] integ_q;

    lf_sat_add #(.W(ACC_W)) u_add (
        .a_i   (integ_q),
        .b_i   (step),
        .sum_o (sum_sat)
    );

    always_comb begin
        step         = err_scaled_i >>> ki_i;
        integ_next_o = sum_sat;
        integ_d      = upd_i ? sum_sat : integ_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            integ_q <= '0;
        end else begin
            integ_q <= integ_d;
        end
    end

    assign integ_q_o = integ_q;
endmodule

// File: rtl/lf_pole.sv
// Single-pole smoothing: y moves a power-of-two fraction toward the target.
module lf_pole #(
    parameter int ACC_W   = 24,
    parameter int SHIFT_W = 4
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     upd_i,
    input  logic signed [ACC_W-1:0]  target_i,
    input  logic [SHIFT_W-1:0]       kpole_i,
    output logic signed [ACC_W-1:0]  y_next_o
);
    logic signed [ACC_W:0]   diff;
    logic signed [ACC_W:0]   step;
    logic signed [ACC_W-1:0] y_d;
    logic signed [ACC_W-1:0] y_q;

    always_comb begin
        diff     = $signed({target_i[ACC_W-1], target_i}) - $signed({y_q[ACC_W-1], y_q});
        step     = diff >>> kpole_i;
        // The result always lies between y and the target, so truncation is exact.
        y_next_o = y_q + step[ACC_W-1:0];
        y_d      = upd_i ? y_next_o : y_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            y_q <= '0;
        end else begin
            y_q <= y_d;
        end
    end
endmodule

// File: rtl/lf_sigma_delta.sv
// First-order noise shaper: the carry of a fraction accumulator is the dither bit.
module lf_sigma_delta #(
    parameter int FRAC_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              upd_i,
    input  logic [FRAC_W-1:0] frac_i,
    output logic              carry_next_o
);
    logic [FRAC_W:0]   sum;
    logic [FRAC_W-1:0] acc_d;
    logic [FRAC_W-1:0] acc_q;

    always_comb begin
        sum          = {1'b0, acc_q} + {1'b0, frac_i};
        carry_next_o = sum[FRAC_W];
        acc_d        = upd_i ? sum[FRAC_W-1:0] : acc_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end
endmodule

// File: rtl/dpll_loop_filter.sv
// Loop filter: proportional + integral (zero), one-pole smoother (pole),
// integer control word plus sigma-delta carry from the fractional bits.
module dpll_loop_filter
    import dpll_lf_pkg::*;
#(
    parameter int ERR_W  = 12,
    parameter int ACC_W  = 24,
    parameter int FRAC_W = 8
) (
    input  logic                                 clk_i,
    input  logic                                 rst_ni,
    input  logic                                 upd_i,
    input  logic signed [ERR_W-1:0]              phase_err_i,
    input  logic [3:0]                           kp_shift_i,
    input  logic [3:0]                           ki_shift_i,
    input  logic [3:0]                           pole_shift_i,
    output logic signed [ACC_W-FRAC_W-1:0]       ctrl_word_o,
    output logic                                 ctrl_strobe_o,
    output logic                                 sd_carry_o
);
    localparam int CTRL_W = ACC_W - FRAC_W;

    typedef struct packed {
        logic signed [CTRL_W-1:0] ctrl;
        logic                     strobe;
        logic                     carry;
    } out_state_t;

    lf_gains_t               gains;
    logic signed [ACC_W-1:0] err_ext;
    logic signed [ACC_W-1:0] err_scaled;
    logic signed [ACC_W-1:0] prop;
    logic signed [ACC_W-1:0] integ_next;
    logic signed [ACC_W-1:0] integ_q;
    logic signed [ACC_W-1:0] pi_sum;
    logic signed [ACC_W-1:0] y_next;
    logic                    carry_next;
    logic signed [CTRL_W:0]  ctrl_wide;
    logic signed [CTRL_W-1:0] ctrl_sat;
    out_state_t              st_d;
    out_state_t              st_q;

    always_comb begin
        gains.kp    = kp_shift_i;
        gains.ki    = ki_shift_i;
        gains.kpole = pole_shift_i;
        err_ext     = ACC_W'(phase_err_i);
        err_scaled  = err_ext <<< FRAC_W;
        prop        = err_scaled >>> gains.kp;
    end

    lf_integrator #(.ACC_W(ACC_W), .SHIFT_W(SHIFT_W)) u_integ (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .upd_i        (upd_i),
        .err_scaled_i (err_scaled),
        .ki_i         (gains.ki),
        .integ_next_o (integ_next),
        .integ_q_o    (integ_q)
    );

    lf_sat_add #(.W(ACC_W)) u_pi_add (
        .a_i   (prop),
        .b_i   (integ_next),
        .sum_o (pi_sum)
    );

    lf_pole #(.ACC_W(ACC_W), .SHIFT_W(SHIFT_W)) u_pole (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .upd_i    (upd_i),
        .target_i (pi_sum),
        .kpole_i  (gains.kpole),
        .y_next_o (y_next)
    );

    lf_sigma_delta #(.FRAC_W(FRAC_W)) u_sd (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .upd_i        (upd_i),
        .frac_i       (y_next[FRAC_W-1:0]),
        .carry_next_o (carry_next)
    );

    always_comb begin
        ctrl_wide = $signed({y_next[ACC_W-1], y_next[ACC_W-1:FRAC_W]})
                  + $signed({{CTRL_W{1'b0}}, carry_next});
        // Adding a non-negative carry can only overflow upward.
        if (!ctrl_wide[CTRL_W] && ctrl_wide[CTRL_W-1]) begin
            ctrl_sat = {1'b0, {(CTRL_W-1){1'b1}}};
        end else begin
            ctrl_sat = ctrl_wide[CTRL_W-1:0];
        end

        st_d        = st_q;
        st_d.strobe = upd_i;
        st_d.carry  = upd_i & carry_next;
        if (upd_i) begin
            st_d.ctrl = ctrl_sat;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_word_o   = st_q.ctrl;
    assign ctrl_strobe_o = st_q.strobe;
    assign sd_carry_o    = st_q.carry;
endmodule

// File: rtl/lf_checker.sv
module lf_checker #(
    parameter int ERR_W  = 12,
    parameter int ACC_W  = 24,
    parameter int CTRL_W = 16
) (
    input logic                     clk_i,
    input logic                     rst_ni,
    input logic                     upd_i,
    input logic signed [ERR_W-1:0]  err_i,
    input logic signed [CTRL_W-1:0] ctrl_i,
    input logic                     strobe_i,
    input logic                     carry_i,
    input logic signed [ACC_W-1:0]  integ_i
);
    a_r2_hold_between_updates: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !upd_i |=> $stable(ctrl_i));

    a_r2_strobe_follows_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
        upd_i |=> strobe_i);

    a_r2_no_strobe_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !upd_i |=> !strobe_i);

    a_r7_carry_only_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        carry_i |-> strobe_i);

    a_r5_no_wrap_upward: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (upd_i && (err_i > 0)) |=> ($signed(integ_i) >= $signed($past(integ_i))));

    a_r5_no_wrap_downward: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (upd_i && (err_i < 0)) |=> ($signed(integ_i) <= $signed($past(integ_i))));
endmodule

bind dpll_loop_filter lf_checker #(
    .ERR_W  (ERR_W),
    .ACC_W  (ACC_W),
    .CTRL_W (ACC_W - FRAC_W)
) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .upd_i    (upd_i),
    .err_i    (phase_err_i),
    .ctrl_i   (ctrl_word_o),
    .strobe_i (ctrl_strobe_o),
    .carry_i  (sd_carry_o),
    .integ_i  (integ_q)
);

// File: tb/dpll_loop_filter_tb.sv
`timescale 1ns/1ps
module dpll_loop_filter_tb;
    localparam int ERR_W  = 12;
    localparam int ACC_W  = 24;
    localparam int FRAC_W = 8;
    localparam int CTRL_W = ACC_W - FRAC_W;
    localparam longint AMAX = (longint'(1) <<< (ACC_W-1)) - 1;
    localparam longint AMIN = -(longint'(1) <<< (ACC_W-1));
    localparam longint CMAX = (longint'(1) <<< (CTRL_W-1)) - 1;
    localparam longint FMOD = longint'(1) <<< FRAC_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic upd = 1'b0;
    logic signed [ERR_W-1:0] err = '0;
    logic [3:0] kp = 4'd0, ki = 4'd0, kpole = 4'd0;
    logic signed [CTRL_W-1:0] ctrl;
    logic strobe, carry;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    longint m_integ, m_y, m_sd, m_ctrl, m_carry;

    always #2 clk = ~clk;

    dpll_loop_filter #(.ERR_W(ERR_W), .ACC_W(ACC_W), .FRAC_W(FRAC_W)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .upd_i(upd), .phase_err_i(err),
        .kp_shift_i(kp), .ki_shift_i(ki), .pole_shift_i(kpole),
        .ctrl_word_o(ctrl), .ctrl_strobe_o(strobe), .sd_carry_o(carry)
    );

    function automatic longint clampa(longint v);
        if (v > AMAX) return AMAX;
        if (v < AMIN) return AMIN;
        return v;
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0; upd = 1'b0; err = '0;
        m_integ = 0; m_y = 0; m_sd = 0; m_ctrl = 0; m_carry = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One update pulse; expected values follow R3, R4, R5, R6, R7, R9.
    task automatic do_update(longint e, string req);
        longint ee, pi, s;
        @(negedge clk);
        err = ERR_W'(e); upd = 1'b1;
        @(negedge clk);
        upd = 1'b0;
        ee = e * FMOD;
        m_integ = clampa(m_integ + (ee >>> ki));
        pi = clampa((ee >>> kp) + m_integ);
        m_y = m_y + ((pi - m_y) >>> kpole);
        s = m_sd + (m_y & (FMOD - 1));
        m_carry = (s >= FMOD) ? 1 : 0;
        m_sd = s & (FMOD - 1);
        m_ctrl = (m_y >>> FRAC_W) + m_carry;
        if (m_ctrl > CMAX) m_ctrl = CMAX;
        check(longint'(ctrl) == m_ctrl, req, longint'(ctrl), m_ctrl);
        check(longint'(carry) == m_carry, {req, "/R7 carry"}, longint'(carry), m_carry);
        check(strobe == 1'b1, "R2 strobe", longint'(strobe), 1);
    endtask

    task automatic t_reset();
        apply_reset();
        @(negedge clk);
        check(ctrl == '0, "R1 ctrl", longint'(ctrl), 0);
        check(strobe == 1'b0, "R1 strobe", longint'(strobe), 0);
        check(carry == 1'b0, "R1 carry", longint'(carry), 0);
    endtask

    task automatic t_prop();
        apply_reset();
        kp = 4'd0; ki = 4'd15; kpole = 4'd0;
        do_update(5, "R3 prop");
        check(longint'(ctrl) == 5, "R3 prop value", longint'(ctrl), 5);
        kp = 4'd3;
        do_update(-40, "R3 prop shifted");
        kp = 4'd9;
        do_update(3, "R3 prop fractional");
    endtask

    task automatic t_hold();
        longint held;
        held = longint'(ctrl);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            err = ERR_W'(100 * i - 400);
            check(longint'(ctrl) == held, "R2 hold", longint'(ctrl), held);
            check(strobe == 1'b0, "R2 idle strobe", longint'(strobe), 0);
        end
    endtask

    task automatic t_integ();
        apply_reset();
        kp = 4'd15; ki = 4'd4; kpole = 4'd0;
        for (int i = 0; i < 10; i++) do_update(-7, "R4 integ");
        ki = 4'd6;
        for (int i = 0; i < 6; i++) do_update(9, "R4 integ rise");
    endtask

    task automatic t_pole();
        longint prev;
        apply_reset();
        kp = 4'd0; ki = 4'd15; kpole = 4'd2;
        prev = 0;
        for (int i = 0; i < 8; i++) begin
            do_update(100, "R6 pole");
            check(longint'(ctrl) >= prev && longint'(ctrl) <= 100, "R6 monotone",
                  longint'(ctrl), prev);
            prev = longint'(ctrl);
        end
    endtask

    task automatic t_density();
        int ncarry;
        longint sum;
        apply_reset();
        kp = 4'd15; ki = 4'd3; kpole = 4'd0;
        do_update(1, "R8 seed");          // integrator fraction = 32/256
        ncarry = 0; sum = 0;
        for (int i = 0; i < 256; i++) begin
            do_update(0, "R8 window");
            ncarry += int'(carry);
            sum += longint'(ctrl);
        end
        check(ncarry == 32, "R8 carry count", ncarry, 32);
        check(sum == 32, "R8 ctrl sum", sum, 32);
    endtask

    task automatic t_saturation();
        apply_reset();
        kp = 4'd15; ki = 4'd0; kpole = 4'd0;
        for (int i = 0; i < 20; i++) do_update(2047, "R5 pos rail");
        check(longint'(ctrl) == CMAX, "R9 ctrl clamp", longint'(ctrl), CMAX);
        do_update(-1, "R5 step back");
        check(longint'(ctrl) > 0, "R5 no wrap up", longint'(ctrl), CMAX);
        apply_reset();
        for (int i = 0; i < 20; i++) do_update(-2048, "R5 neg rail");
        check(longint'(ctrl) == -CMAX - 1, "R5 neg clamp", longint'(ctrl), -CMAX - 1);
        do_update(1, "R5 step up");
        check(longint'(ctrl) < 0, "R5 no wrap down", longint'(ctrl), -CMAX - 1);
    endtask

    initial begin
        t_reset();
        t_prop();
        t_hold();
        t_integ();
        t_pole();
        t_density();
        t_saturation();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule